// File: doc/BRIEF.md
# Chained Indirect Operand Address Resolver

This block turns the five-digit decimal operand address of a freshly fetched instruction into the address that execution will actually use. Each address digit carries a flag bit next to its 4-bit BCD value. When indirection is enabled for the operand and the flag is set on the units digit, the address names a memory location rather than data. The block reads a five-digit address word from memory there and puts it in place of the operand. It keeps doing this until a word arrives whose units digit has no flag.

The pointer gives the position of the units digit of the stored word. The other four digits are read from the four positions just below it, and the address count wraps around the memory size. The word always has five digits, whatever flags sit inside it. Interior flags are removed before the word is used as an address. Only the block's result register receives the new address, because the block has no write path to memory.

A depth limit supplied with each request stops a circular or overlong chain. When the limit is reached, the block finishes with an error flag. A request starts with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, with the address on `res_addr`.

Top module: `indirect_addr_resolver`

## Requirements
- R1: When `start` arrives with the units flag (bit 4 of `raw_addr`) clear, `done` rises the next cycle with `err` low and no memory read. `res_addr` holds the BCD values of the raw digits. Digit i of `raw_addr` is bits [5i+4:5i]: bit 5i+4 is the flag and bits [5i+3:5i] are the value, with i=0 as the units digit.
- R2: When `ind_en` is low, the address is treated as direct even if the units flag is set. Timing and result follow R1.
- R3: One indirection level issues reads on consecutive cycles, one cycle after `start` or after the previous level. The first read is at the pointer, which is the units digit, and each following read is one address lower, for five reads in all. `rd_data` (bit 4 flag, bits 3:0 value) is sampled one cycle after its read.
- R4: The read address wraps from 0 to MEM_SIZE-1 and never leaves the range 0 to MEM_SIZE-1.
- R5: Interior flags in a fetched word neither shorten it nor change its value. All five digits are used and their flags are dropped.
- R6: When the units digit of a fetched word carries a flag, that word becomes the next pointer and resolution repeats.
- R7: `done` comes exactly 1 + 6·L cycles after the `start` cycle, where L is the number of levels read.
- R8: When a chain would need more than `depth_limit` levels, `done` and `err` rise together after `depth_limit` levels. `res_addr` then holds the last still-indirect address with its flags dropped. A limit of 0 on an indirect address gives an error after one cycle with no reads. A chain that needs exactly `depth_limit` levels succeeds.
- R9: `done` is a single-cycle pulse and `err` is high only while `done` is high.
- R10: A `start` that arrives while a resolution is in progress is ignored. It produces no extra reads, no extra `done` and no change to the running result.
- R11: During reset, `done`, `err` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| ind_en | input | 1 | Indirection allowed for this operand |
| raw_addr | input | DIGITS*5 | Operand address as flag+BCD digits, units digit lowest |
| depth_limit | input | DEPTH_W | Maximum number of indirection levels |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | DIGITS*4 | BCD read address |
| rd_data | input | 5 | Digit read back one cycle after the request (flag, value) |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Depth limit reached, valid with `done` |
| res_addr | output | DIGITS*4 | Resolved BCD address, held until the next result |

## Verification
The bench uses the default five-digit address, a memory of 20000 positions and a 4-bit depth limit. The 20000-position modulus lets a pointer of 00002 run its reads down through 00000 into 19999 and 19998. The small limit width lets a location that points to itself reach its limit after five levels, in 31 cycles. The scoreboard models the memory on its own and predicts every read address, the result, the error flag and the exact cycle of `done`. It also flags any extra read or completion, such as one caused by a `start` given while the block is busy.

// File: rtl/iadr_pkg.sv
package iadr_pkg;
   // widest address supported by the shared conversion helper
   localparam int MAXD = 8;

   // BCD digit string (units digit lowest) to binary
   function automatic int unsigned bcd_to_int(input logic [MAXD*4-1:0] v, input int n);
      int unsigned r;
      r = 0;
      for (int i = MAXD - 1; i >= 0; i--) begin
         if (i < n) r = r * 10 + int'(v[i*4 +: 4]);
      end
      return r;
   endfunction
endpackage

// File: rtl/iar_addr_step.sv
// Read address = base - offset, wrapped modulo MEM_SIZE, in BCD.
module iar_addr_step
   import iadr_pkg::*;
#(
   parameter int DIGITS   = 5,
   parameter int MEM_SIZE = 20000,
   parameter int IW       = 3
) (
   input  logic [DIGITS*4-1:0] base,
   input  logic [IW-1:0]       offset,
   output logic [DIGITS*4-1:0] addr
);
   int unsigned b, o, t;

   always_comb begin
      b = bcd_to_int((MAXD*4)'(base), DIGITS);
      o = 32'(offset);
      t = (b >= o) ? (b - o) : (b + MEM_SIZE - o);
      for (int i = 0; i < DIGITS; i++) begin
         addr[i*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
   end
endmodule

// File: rtl/iar_word_gather.sv
// Holds the lower digits of the word being fetched and the units flag.
module iar_word_gather #(
   parameter int DIGITS = 5,
   parameter int IW     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_en,
   input  logic [IW-1:0]           cap_idx,
   input  logic [4:0]              rd_data,
   output logic [(DIGITS-1)*4-1:0] word_lo,
   output logic                    units_flag
);
   for (genvar g = 0; g < DIGITS - 1; g++) begin : g_dig
      logic [3:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            q <= '0;
         else if (cap_en && cap_idx == IW'(g))  q <= rd_data[3:0];
      end
      assign word_lo[g*4 +: 4] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           units_flag <= 1'b0;
      else if (cap_en && cap_idx == '0)     units_flag <= rd_data[4];
   end
endmodule

// File: rtl/indirect_addr_resolver.sv
module indirect_addr_resolver
   import iadr_pkg::*;
#(
   parameter int DIGITS   = 5,
   parameter int MEM_SIZE = 20000,
   parameter int DEPTH_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 ind_en,
   input  logic [DIGITS*5-1:0]  raw_addr,
   input  logic [DEPTH_W-1:0]   depth_limit,
   output logic                 rd_en,
   output logic [DIGITS*4-1:0]  rd_addr,
   input  logic [4:0]           rd_data,
   output logic                 done,
   output logic                 err,
   output logic [DIGITS*4-1:0]  res_addr
);
   localparam int AW   = DIGITS * 4;
   localparam int IW   = $clog2(DIGITS);
   localparam int LO_W = (DIGITS - 1) * 4;

   // elaboration-time parameter checks
   if (DIGITS < 2 || DIGITS > MAXD) begin : g_bad_digits
      $error("DIGITS must lie in 2..%0d", MAXD);
   end
   if (MEM_SIZE <= DIGITS || MEM_SIZE > 10 ** DIGITS) begin : g_bad_size
      $error("MEM_SIZE must exceed DIGITS and fit in DIGITS decimal digits");
   end
   if (DEPTH_W < 1) begin : g_bad_depth
      $error("DEPTH_W must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_READ, S_COLLECT} st_t;

   st_t                st;
   logic [AW-1:0]      ptr;
   logic [IW-1:0]      idx;
   logic [DEPTH_W-1:0] lvl;
   logic [DEPTH_W-1:0] lvl_next;
   logic [AW-1:0]      raw_val;
   logic               raw_units_f;
   logic [DIGITS-2:0]  inner_flags;
   logic               unused_inner;
   logic               cap_en;
   logic [IW-1:0]      cap_idx;
   logic [LO_W-1:0]    word_lo;
   logic               word_units_f;
   logic [AW-1:0]      fetched;

   // split raw digits into values and flags
   for (genvar g = 0; g < DIGITS; g++) begin : g_raw
      assign raw_val[g*4 +: 4] = raw_addr[g*5 +: 4];
      if (g > 0) begin : g_inner
         assign inner_flags[g-1] = raw_addr[g*5 + 4];
      end
   end
   assign raw_units_f  = raw_addr[4];
   assign unused_inner = ^inner_flags;

   assign rd_en   = (st == S_READ);
   assign cap_en  = (st == S_READ) && (idx != '0);
   assign cap_idx = IW'(idx - 1'b1);
   assign fetched = {rd_data[3:0], word_lo};
   assign lvl_next = lvl + 1'b1;

   iar_addr_step #(.DIGITS(DIGITS), .MEM_SIZE(MEM_SIZE), .IW(IW)) u_step (
      .base   (ptr),
      .offset (idx),
      .addr   (rd_addr)
   );

   iar_word_gather #(.DIGITS(DIGITS), .IW(IW)) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .rd_data    (rd_data),
      .word_lo    (word_lo),
      .units_flag (word_units_f)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         ptr      <= '0;
         idx      <= '0;
         lvl      <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         res_addr <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  if (ind_en && raw_units_f) begin
                     if (depth_limit == '0) begin
                        done     <= 1'b1;
                        err      <= 1'b1;
                        res_addr <= raw_val;
                     end else begin
                        st  <= S_READ;
                        ptr <= raw_val;
                        idx <= '0;
                        lvl <= '0;
                     end
                  end else begin
                     done     <= 1'b1;
                     res_addr <= raw_val;
                  end
               end
            end
            S_READ: begin
               if (idx == IW'(DIGITS - 1)) st  <= S_COLLECT;
               else                        idx <= idx + 1'b1;
            end
            S_COLLECT: begin
               if (word_units_f && lvl_next < depth_limit) begin
                  st  <= S_READ;
                  ptr <= fetched;
                  idx <= '0;
                  lvl <= lvl_next;
               end else begin
                  st       <= S_IDLE;
                  done     <= 1'b1;
                  err      <= word_units_f;
                  res_addr <= fetched;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/iar_checker.sv
module iar_checker
   import iadr_pkg::*;
#(
   parameter int DIGITS   = 5,
   parameter int MEM_SIZE = 20000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                ind_en,
   input logic                done,
   input logic                err,
   input logic                rd_en,
   input logic [DIGITS*4-1:0] rd_addr
);
   logic busy;
   logic rd_ok;

   // independent view of whether a request is outstanding
   always_ff @(posedge clk) begin
      if (!rst_n)               busy <= 1'b0;
      else if (done)            busy <= start;
      else if (!busy && start)  busy <= 1'b1;
   end

   assign rd_ok = bcd_to_int((MAXD*4)'(rd_addr), DIGITS) < MEM_SIZE;

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);
   // R9
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   // R10
   read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_en);
   // R4
   read_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> rd_ok);
   // R2
   direct_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && !ind_en |=> done && !err);
endmodule

bind indirect_addr_resolver iar_checker #(.DIGITS(DIGITS), .MEM_SIZE(MEM_SIZE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .ind_en  (ind_en),
   .done    (done),
   .err     (err),
   .rd_en   (rd_en),
   .rd_addr (rd_addr)
);

// File: tb/indirect_addr_resolver_test.sv
module indirect_addr_resolver_test;
   localparam int DIG = 5;
   localparam int MSZ = 20000;
   localparam int DW  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              ind_en = 1'b0;
   logic [DIG*5-1:0]  raw_addr = '0;
   logic [DW-1:0]     depth_limit = '0;
   logic              rd_en;
   logic [DIG*4-1:0]  rd_addr;
   logic [4:0]        rd_data = '0;
   logic              done, err;
   logic [DIG*4-1:0]  res_addr;

   always #2 clk = ~clk;

   indirect_addr_resolver #(.DIGITS(DIG), .MEM_SIZE(MSZ), .DEPTH_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ind_en(ind_en),
      .raw_addr(raw_addr), .depth_limit(depth_limit), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .err(err),
      .res_addr(res_addr)
   );

   typedef struct {
      int    res;
      bit    e;
      int    cyc;
      string req;
   } exp_t;

   logic [4:0] mem [int];
   exp_t       exp_q[$];
   int         rd_q[$];
   string      rd_req = "R3";
   int         cyc = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         fin = 0;

   function automatic int bcd2i(input logic [DIG*4-1:0] v);
      int r = 0;
      for (int i = DIG - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
      return r;
   endfunction

   function automatic logic [4:0] peek(input int a);
      return mem.exists(a) ? mem[a] : 5'b0;
   endfunction

   function automatic logic [DIG*4-1:0] strip(input logic [DIG*5-1:0] w);
      logic [DIG*4-1:0] r;
      for (int i = 0; i < DIG; i++) r[i*4 +: 4] = w[i*5 +: 4];
      return r;
   endfunction

   function automatic logic [DIG*5-1:0] mk_raw(input int value, input logic [DIG-1:0] flags);
      logic [DIG*5-1:0] r;
      int t = value;
      for (int i = 0; i < DIG; i++) begin
         r[i*5 +: 5] = {flags[i], 4'(t % 10)};
         t = t / 10;
      end
      return r;
   endfunction

   // store a word whose units digit sits at ua, higher digits below it
   task automatic poke_word(input int ua, input int value, input logic [DIG-1:0] flags);
      int t = value;
      for (int k = 0; k < DIG; k++) begin
         mem[(ua - k + MSZ) % MSZ] = {flags[k], 4'(t % 10)};
         t = t / 10;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // memory model: data one cycle after the request
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) rd_data <= peek(bcd2i(rd_addr));
   end

   // monitor
   exp_t m_e;
   int   m_a;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_en) begin
            if (rd_q.size() == 0) check(1'b0, "R10", "unexpected read", bcd2i(rd_addr), -1);
            else begin
               m_a = rd_q.pop_front();
               check(bcd2i(rd_addr) == m_a, rd_req, "read address", bcd2i(rd_addr), m_a);
            end
         end
         if (done) begin
            if (exp_q.size() == 0) check(1'b0, "R10", "unexpected done", cyc, -1);
            else begin
               m_e = exp_q.pop_front();
               check(bcd2i(res_addr) == m_e.res, m_e.req, "result", bcd2i(res_addr), m_e.res);
               check(err == m_e.e, m_e.req, "error flag", int'(err), int'(m_e.e));
               check(cyc == m_e.cyc, "R7", "done cycle", cyc, m_e.cyc);
            end
         end
         if (err && !done) check(1'b0, "R9", "err without done", 1, 0);
      end
   end

   // driver: model the chain, queue expectations, pulse start
   task automatic run(input string req, input logic [DIG*5-1:0] raw, input bit ie,
                      input int lim, input int inject_at);
      logic [DIG*5-1:0] cur = raw;
      int   lvl = 0;
      bit   e = 0;
      int   p;
      exp_t x;
      if (ie) begin
         while (cur[4]) begin
            if (lvl >= lim) begin e = 1; break; end
            p = bcd2i(strip(cur));
            for (int k = 0; k < DIG; k++) begin
               rd_q.push_back((p - k + MSZ) % MSZ);
               cur[k*5 +: 5] = peek((p - k + MSZ) % MSZ);
            end
            lvl++;
         end
      end
      rd_req = req;
      @(negedge clk);
      x.res = bcd2i(strip(cur));
      x.e   = e;
      x.cyc = cyc + 1 + 6 * lvl;
      x.req = req;
      exp_q.push_back(x);
      start = 1'b1; raw_addr = raw; ind_en = ie; depth_limit = DW'(lim);
      @(negedge clk);
      start = 1'b0;
      if (inject_at > 0) begin
         repeat (inject_at - 1) @(negedge clk);
         start = 1'b1; raw_addr = mk_raw(3000, 5'b00001); ind_en = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      poke_word(500, 780, 5'b00000);
      poke_word(650, 15225, 5'b00001);
      poke_word(15225, 12500, 5'b00000);
      poke_word(1000, 43219, 5'b01010);
      poke_word(2, 31415, 5'b00000);
      poke_word(3000, 3000, 5'b00001);

      repeat (3) @(negedge clk);
      // R11 reset state
      check(done == 1'b0, "R11", "done in reset", int'(done), 0);
      check(err == 1'b0, "R11", "err in reset", int'(err), 0);
      check(rd_en == 1'b0, "R11", "rd_en in reset", int'(rd_en), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run("R1", mk_raw(12345, 5'b00000), 1'b1, 4, 0);
      run("R1", mk_raw(700, 5'b10100), 1'b1, 4, 0);   // interior flags only: direct
      run("R2", mk_raw(500, 5'b00001), 1'b0, 4, 0);
      run("R3", mk_raw(500, 5'b00001), 1'b1, 4, 0);
      run("R5", mk_raw(1000, 5'b00001), 1'b1, 4, 0);
      run("R4", mk_raw(2, 5'b00001), 1'b1, 4, 0);
      run("R6", mk_raw(650, 5'b00001), 1'b1, 4, 0);
      run("R8", mk_raw(650, 5'b00001), 1'b1, 2, 0);   // exactly enough levels
      run("R8", mk_raw(650, 5'b00001), 1'b1, 1, 0);   // one short: error
      run("R8", mk_raw(500, 5'b00001), 1'b1, 0, 0);   // zero limit: no reads
      run("R8", mk_raw(3000, 5'b00001), 1'b1, 5, 0);  // circular chain
      run("R10", mk_raw(500, 5'b00001), 1'b1, 4, 3);  // start while busy

      repeat (20) @(negedge clk);
      // R10 nothing left over after the ignored start
      check(exp_q.size() == 0, "R10", "pending completions", exp_q.size(), 0);
      check(rd_q.size() == 0, "R10", "pending reads", rd_q.size(), 0);
      check(rd_en == 1'b0, "R10", "idle read request", int'(rd_en), 0);
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule